// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a four-beat burst access to a synchronous memory. A new base address is captured on a rising clock edge whenever one of two active-low strobes is asserted. One strobe comes from the processor side and one from the memory controller side. After capture, the upper address bits stay frozen. The two lowest bits then step through a four-entry sequence on every cycle in which the active-low advance input is asserted, and they hold while it is not.

A static order input picks the sequence. Interleaved order flips the low bits with an XOR against the beat number. Linear order adds the beat number modulo four. Either way, the burst stays inside its aligned four-word block and comes back to its starting word after four beats. A strobe at any time abandons the running burst and starts a fresh one. The processor strobe only counts while the primary chip enable (active low) is asserted.

All pins are plain control and address signals; there is no valid/ready handshake because the block has no back-pressure: the address is valid on every cycle and is owned by the memory control logic that drives the strobes and advance.

Top module: `burst_addr_seq`

## Requirements
- R1: With `ctl_strb_n` low at a rising edge, `addr_q` equals the sampled `addr_d` after that edge, whatever `chip_en_n` is.
- R2: With `cpu_strb_n` low at a rising edge, `addr_d` is loaded only if `chip_en_n` is also low. With `chip_en_n` high, the processor strobe is ignored and `addr_q` keeps its value.
- R3: With no strobe active, `adv_n` low at a rising edge moves the burst to its next beat. `adv_n` high holds `addr_q` unchanged.
- R4: A strobe and `adv_n` low in the same cycle load the new base address with beat number 0; no step is taken.
- R5: With `order_lin` = 0 (interleaved), bits [1:0] of `addr_q` equal the captured start bits XOR the beat number n (0..3).
- R6: With `order_lin` = 1 (linear), bits [1:0] of `addr_q` equal (captured start bits + n) mod 4.
- R7: Bits above bit 1 of `addr_q` never change without a load. After the fourth step, the burst wraps back to its start word inside the same four-word block.
- R8: `last_beat` is 1 exactly when the number of steps since the last load, taken mod 4, is 3. It is 0 in the cycle after any load.
- R9: While `rst_n` is low, `addr_q` is 0 and `last_beat` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_d | input | ADDR_W | Address presented with a strobe |
| cpu_strb_n | input | 1 | Processor-side address strobe, active low, gated by chip enable |
| ctl_strb_n | input | 1 | Controller-side address strobe, active low, ungated |
| chip_en_n | input | 1 | Primary chip enable, active low, gates the processor strobe |
| adv_n | input | 1 | Burst advance, active low |
| order_lin | input | 1 | Burst order: 0 interleaved, 1 linear |
| addr_q | output | ADDR_W | Current burst address |
| last_beat | output | 1 | High on the final beat of the four-beat sequence |

## Verification
The bench builds the block with its defaults: an 8-bit address and a 2-bit beat counter. With these values, every start offset in both orders can be swept exhaustively. Base addresses at the top of the range (0xFF) are also reachable, which shows that wrapping stays inside the block and never carries into the upper bits. The narrow address also makes it cheap to hit strobe-and-advance collisions, gated processor strobes and restarts in the middle of a burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORD_XOR = 1'b0,
    ORD_ADD = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_load_ctrl.sv
module burst_load_ctrl (
  input  logic cpu_strb_n,
  input  logic ctl_strb_n,
  input  logic chip_en_n,
  input  logic adv_n,
  output logic load,
  output logic step
);
  logic cpu_take;

  always_comb begin
    cpu_take = ~cpu_strb_n & ~chip_en_n;
    load     = cpu_take | ~ctl_strb_n;
    step     = ~load & ~adv_n;
  end
endmodule

// File: rtl/burst_beat_cnt.sv
module burst_beat_cnt #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  output logic [BEAT_W-1:0] beat,
  output logic              last
);
  localparam logic [BEAT_W-1:0] BEAT_TOP = {BEAT_W{1'b1}};
  localparam logic [BEAT_W-1:0] BEAT_ONE = {{(BEAT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    beat <= '0;
    else if (load) beat <= '0;
    else if (step) beat <= beat + BEAT_ONE;
  end

  assign last = (beat == BEAT_TOP);
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start,
  input  logic [BEAT_W-1:0] beat,
  input  burst_order_e      order,
  output logic [BEAT_W-1:0] low
);
  logic [BEAT_W-1:0] xor_low;
  logic [BEAT_W-1:0] add_low;

  for (genvar i = 0; i < BEAT_W; i++) begin : g_xor
    assign xor_low[i] = start[i] ^ beat[i];
  end

  assign add_low = start + beat;

  always_comb begin
    unique case (order)
      ORD_ADD: low = add_low;
      default: low = xor_low;
    endcase
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_d,
  input  logic              cpu_strb_n,
  input  logic              ctl_strb_n,
  input  logic              chip_en_n,
  input  logic              adv_n,
  input  logic              order_lin,
  output logic [ADDR_W-1:0] addr_q,
  output logic              last_beat
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic              load;
  logic              step;
  logic [HI_W-1:0]   base_hi;
  logic [BEAT_W-1:0] start_lo;
  logic [BEAT_W-1:0] beat;
  logic [BEAT_W-1:0] cur_lo;
  burst_order_e      order;

  assign order = burst_order_e'(order_lin);

  burst_load_ctrl u_ctrl (
    .cpu_strb_n (cpu_strb_n),
    .ctl_strb_n (ctl_strb_n),
    .chip_en_n  (chip_en_n),
    .adv_n      (adv_n),
    .load       (load),
    .step       (step)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_hi  <= '0;
      start_lo <= '0;
    end else if (load) begin
      base_hi  <= addr_d[ADDR_W-1:BEAT_W];
      start_lo <= addr_d[BEAT_W-1:0];
    end
  end

  burst_beat_cnt #(.BEAT_W(BEAT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .step  (step),
    .beat  (beat),
    .last  (last_beat)
  );

  burst_order_map #(.BEAT_W(BEAT_W)) u_map (
    .start (start_lo),
    .beat  (beat),
    .order (order),
    .low   (cur_lo)
  );

  assign addr_q = {base_hi, cur_lo};
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 8,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_d,
  input logic              cpu_strb_n,
  input logic              ctl_strb_n,
  input logic              chip_en_n,
  input logic              adv_n,
  input logic              order_lin,
  input logic [ADDR_W-1:0] addr_q,
  input logic              last_beat
);
  logic strobe_hit;
  assign strobe_hit = ~ctl_strb_n | (~cpu_strb_n & ~chip_en_n);

  assert_ctl_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_strb_n |=> addr_q == $past(addr_d));

  assert_cpu_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_strb_n && chip_en_n && ctl_strb_n && adv_n) |=>
      ($stable(addr_q) || order_lin != $past(order_lin)));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_hit && adv_n) |=>
      ($stable(addr_q) || order_lin != $past(order_lin)));

  assert_linear_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_hit && !adv_n && order_lin) |=>
      (!order_lin || addr_q[BEAT_W-1:0] == BEAT_W'($past(addr_q[BEAT_W-1:0]) + 1'b1)));

  assert_upper_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_hit |=> $stable(addr_q[ADDR_W-1:BEAT_W]));

  assert_last_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_hit |=> !last_beat);

  always_comb begin
    if (!rst_n) begin
      assert_reset_R9: assert (addr_q == '0 && !last_beat);
    end
  end
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr_d     (addr_d),
  .cpu_strb_n (cpu_strb_n),
  .ctl_strb_n (ctl_strb_n),
  .chip_en_n  (chip_en_n),
  .adv_n      (adv_n),
  .order_lin  (order_lin),
  .addr_q     (addr_q),
  .last_beat  (last_beat)
);

// File: tb/sim_burst_addr_seq.sv
`timescale 1ns/1ps
module sim_burst_addr_seq;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_d = '0;
  logic          cpu_strb_n = 1'b1;
  logic          ctl_strb_n = 1'b1;
  logic          chip_en_n = 1'b1;
  logic          adv_n = 1'b1;
  logic          order_lin = 1'b0;
  logic [AW-1:0] addr_q;
  logic          last_beat;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [AW-1:0] addr;
    logic          last;
    string         tag;
  } exp_t;
  exp_t sb[$];

  logic [AW-3:0] m_hi = '0;
  logic [1:0]    m_start = '0;
  logic [1:0]    m_n = '0;

  always #2 clk = ~clk;

  burst_addr_seq u0 (
    .clk(clk), .rst_n(rst_n), .addr_d(addr_d), .cpu_strb_n(cpu_strb_n),
    .ctl_strb_n(ctl_strb_n), .chip_en_n(chip_en_n), .adv_n(adv_n),
    .order_lin(order_lin), .addr_q(addr_q), .last_beat(last_beat)
  );

  function automatic logic [1:0] exp_low(logic [1:0] s, logic [1:0] n, logic lin);
    return lin ? 2'(s + n) : (s ^ n);
  endfunction

  task automatic drive(input logic cpu, input logic ctl, input logic ce, input logic adv,
                       input logic [AW-1:0] a, input logic lin, input string tag);
    exp_t e;
    @(negedge clk);
    cpu_strb_n = cpu; ctl_strb_n = ctl; chip_en_n = ce; adv_n = adv;
    addr_d = a; order_lin = lin;
    if ((!cpu && !ce) || !ctl) begin
      m_hi = a[AW-1:2]; m_start = a[1:0]; m_n = 2'd0;
    end else if (!adv) begin
      m_n = m_n + 2'd1;
    end
    e.addr = {m_hi, exp_low(m_start, m_n, lin)};
    e.last = (m_n == 2'd3);
    e.tag  = tag;
    sb.push_back(e);
  endtask

  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (addr_q !== e.addr || last_beat !== e.last) begin
        errors++;
        $display("FAIL %s: addr_q=%h last=%b expected addr=%h last=%b",
                 e.tag, addr_q, last_beat, e.addr, e.last);
      end
    end
  end

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (addr_q !== '0 || last_beat !== 1'b0) begin
      errors++;
      $display("FAIL R9 reset: addr_q=%h last=%b expected 00 0", addr_q, last_beat);
    end
    rst_n = 1'b1;

    // R1 R5 R8 R7: controller strobe with chip enable off, interleaved, wrap
    drive(1, 0, 1, 1, 8'h41, 0, "R1 ctl load");
    for (int i = 0; i < 4; i++) drive(1, 1, 1, 0, 8'h00, 0, "R5 R8 R7 interleave step");
    // R3 pause
    drive(1, 1, 1, 1, 8'h00, 0, "R3 hold");
    drive(1, 1, 1, 1, 8'h00, 0, "R3 hold");
    // R2 gated processor strobe ignored
    drive(0, 1, 1, 1, 8'hA6, 0, "R2 cpu ignored");
    drive(1, 1, 1, 0, 8'h00, 0, "R2 step after ignore");
    // R2 processor strobe with enable, linear order
    drive(0, 1, 0, 1, 8'h92, 1, "R2 cpu load");
    for (int i = 0; i < 4; i++) drive(1, 1, 0, 0, 8'h00, 1, "R6 R8 linear step");
    // R4 strobe with advance
    drive(1, 1, 0, 0, 8'h00, 1, "R6 step");
    drive(1, 0, 1, 0, 8'h37, 1, "R4 strobe beats adv");
    drive(1, 1, 1, 0, 8'h00, 1, "R4 next step");
    // restart mid-burst
    drive(0, 1, 0, 1, 8'h5C, 0, "R2 restart");
    drive(1, 1, 0, 0, 8'h00, 0, "R5 step");
    // R7 top of range stays in block
    drive(1, 0, 1, 1, 8'hFF, 1, "R7 top load");
    for (int i = 0; i < 5; i++) drive(1, 1, 1, 0, 8'h00, 1, "R7 top wrap");
    // exhaustive sweep of start offsets in both orders
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        drive(1, 0, 1, 1, 8'(8'hC0 + s), m[0], "R1 sweep load");
        for (int k = 0; k < 4; k++)
          drive(1, 1, 1, 0, 8'h00, m[0], m[0] ? "R6 sweep" : "R5 sweep");
      end
    end
    drive(1, 1, 1, 1, 8'h00, 0, "R3 idle");
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule